// File: doc/BRIEF.md
# Scaled 64-bit System Counter

This block is a free-running 64-bit time base that a chip's timers read. It sits on a simple 32-bit register bus that has a byte address, a write strobe, write data and combinational read data. It advances once for each cycle in which its `tick` input is high. Software starts and stops the counter through a control register. Software can also load or clear the count, one 32-bit half at a time.

When scaling is on, a tick does not add one. It adds an unsigned fixed-point step with 8 integer bits and 24 fraction bits, taken from a scale register. A hidden 24-bit fraction accumulator sits below the 64-bit integer count, and its carry feeds the count. This lets the visible count run at a fractional rate of the tick rate, for example one count per sixteen ticks. The present count also leaves the block on a dedicated output for the timers that compare against it.

Top module: `sysctr_top`

## Requirements
- R1: After reset the count is 0 and the fraction is 0. Control reads 0, so the counter is disabled and scaling is off. The scale register (byte offset 0x10) reads 0x01000000, which is a step of 1.0.
- R2: While control bit 0 (enable) is clear, the count never changes, whatever `tick` does.
- R3: With enable set and scaling off, the count rises by exactly 1 for each cycle with `tick` high (100 ticks from 0 give 100), and it holds when `tick` is low.
- R4: The control register is at byte offset 0x0. Bit 0 is enable and bit 2 is scale-enable, so writing 5 sets both. A read returns those two bits in place and 0 in every other bit.
- R5: With enable and scale-enable set, each tick adds the 8.24 scale value to the {count, fraction} pair. A scale of 0x00100000 gives 1/16 rate: from 100, 160 ticks give 110.
- R6: The low count half is at 0x8 and the high half is at 0xC. Both are writable, and reads return the current count directly, with no snapshot.
- R7: A write to either count half clears the fraction. If the write falls in a cycle with an enabled tick, the write wins and that tick adds nothing.
- R8: The status register at 0x4 reads 0 and ignores writes.
- R9: Writing the scale-enable bit leaves the count and the fraction unchanged. Only later ticks use the new step.
- R10: A carry out of the low 32 bits of the count increments the high half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count-advance strobe, one step per high cycle |
| bus_addr | input | ADDR_W (5) | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| count_value | output | 64 | Present integer count |

## Verification
The bench targets the fraction accumulator directly. It stops a scaled run at half a count, then toggles scale-enable and ticks again. A design that dropped or reset the fraction on that control write would end one count short. It also loads the count after leaving a half count pending. A design that kept the fraction would then show a count one too high a few ticks later. A write and an enabled tick are driven in the same cycle, where a design with the wrong priority would read one more than the written value. Finally the low half is rolled over from all ones, which catches a design that loses the carry into the high word.

// File: rtl/sysctr_pkg.sv
package sysctr_pkg;
    localparam int unsigned CNT_W  = 64;
    localparam int unsigned REG_W  = 32;
    localparam int unsigned FRAC_W = 24;
    localparam int unsigned ACC_W  = CNT_W + FRAC_W;

    localparam logic [REG_W-1:0] UNIT_STEP = REG_W'(1) << FRAC_W;

    localparam int unsigned OFF_CTRL  = 'h00;
    localparam int unsigned OFF_STAT  = 'h04;
    localparam int unsigned OFF_CNTLO = 'h08;
    localparam int unsigned OFF_CNTHI = 'h0C;
    localparam int unsigned OFF_SCALE = 'h10;

    localparam int unsigned BIT_EN  = 0;
    localparam int unsigned BIT_SEN = 2;

    typedef struct packed {
        logic ctrl;
        logic cnt_lo;
        logic cnt_hi;
        logic scale;
    } wsel_t;

    typedef struct packed {
        logic              en;
        logic              sen;
        logic [REG_W-1:0]  scale;
        logic [CNT_W-1:0]  count;
        logic [FRAC_W-1:0] frac;
    } state_t;
endpackage

// File: rtl/sysctr_wrdec.sv
module sysctr_wrdec
    import sysctr_pkg::*;
#(
    parameter int unsigned ADDR_W = 5
) (
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output wsel_t             sel
);
    always_comb begin
        sel        = '0;
        sel.ctrl   = we && (addr == ADDR_W'(OFF_CTRL));
        sel.cnt_lo = we && (addr == ADDR_W'(OFF_CNTLO));
        sel.cnt_hi = we && (addr == ADDR_W'(OFF_CNTHI));
        sel.scale  = we && (addr == ADDR_W'(OFF_SCALE));
    end
endmodule

// File: rtl/sysctr_step.sv
module sysctr_step
    import sysctr_pkg::*;
(
    input  logic [CNT_W-1:0]  count_in,
    input  logic [FRAC_W-1:0] frac_in,
    input  logic [REG_W-1:0]  step,
    output logic [CNT_W-1:0]  count_out,
    output logic [FRAC_W-1:0] frac_out
);
    logic [ACC_W-1:0] acc;

    always_comb begin
        acc       = {count_in, frac_in} + ACC_W'(step);
        count_out = acc[ACC_W-1:FRAC_W];
        frac_out  = acc[FRAC_W-1:0];
    end
endmodule

// File: rtl/sysctr_rdmux.sv
module sysctr_rdmux
    import sysctr_pkg::*;
#(
    parameter int unsigned ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              en,
    input  logic              sen,
    input  logic [REG_W-1:0]  scale,
    input  logic [CNT_W-1:0]  count,
    output logic [REG_W-1:0]  rdata
);
    always_comb begin
        rdata = '0;
        unique case (addr)
            ADDR_W'(OFF_CTRL): begin
                rdata[BIT_EN]  = en;
                rdata[BIT_SEN] = sen;
            end
            ADDR_W'(OFF_CNTLO): rdata = count[REG_W-1:0];
            ADDR_W'(OFF_CNTHI): rdata = count[CNT_W-1:REG_W];
            ADDR_W'(OFF_SCALE): rdata = scale;
            default:            rdata = '0;
        endcase
    end
endmodule

// File: rtl/sysctr_top.sv
module sysctr_top
    import sysctr_pkg::*;
#(
    parameter int unsigned ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic [CNT_W-1:0]  count_value
);
    state_t            state_d, state_q;
    wsel_t             wsel;
    logic [REG_W-1:0]  step_sel;
    logic [CNT_W-1:0]  stepped_count;
    logic [FRAC_W-1:0] stepped_frac;
    logic              ctl_en, ctl_sen;

    sysctr_wrdec #(.ADDR_W(ADDR_W)) u_wrdec (
        .we   (bus_we),
        .addr (bus_addr),
        .sel  (wsel)
    );

    assign step_sel = state_q.sen ? state_q.scale : UNIT_STEP;

    sysctr_step u_step (
        .count_in  (state_q.count),
        .frac_in   (state_q.frac),
        .step      (step_sel),
        .count_out (stepped_count),
        .frac_out  (stepped_frac)
    );

    always_comb begin
        state_d = state_q;
        if (tick && state_q.en) begin
            state_d.count = stepped_count;
            state_d.frac  = stepped_frac;
        end
        if (wsel.ctrl) begin
            state_d.en  = bus_wdata[BIT_EN];
            state_d.sen = bus_wdata[BIT_SEN];
        end
        if (wsel.scale) begin
            state_d.scale = bus_wdata;
        end
        if (wsel.cnt_lo) begin
            state_d.count = {state_q.count[CNT_W-1:REG_W], bus_wdata};
            state_d.frac  = '0;
        end
        if (wsel.cnt_hi) begin
            state_d.count = {bus_wdata, state_q.count[REG_W-1:0]};
            state_d.frac  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q       <= '0;
            state_q.scale <= UNIT_STEP;
        end else begin
            state_q <= state_d;
        end
    end

    assign ctl_en      = state_q.en;
    assign ctl_sen     = state_q.sen;
    assign count_value = state_q.count;

    sysctr_rdmux #(.ADDR_W(ADDR_W)) u_rdmux (
        .addr  (bus_addr),
        .en    (state_q.en),
        .sen   (state_q.sen),
        .scale (state_q.scale),
        .count (state_q.count),
        .rdata (bus_rdata)
    );
endmodule

// File: rtl/sysctr_chk.sv
module sysctr_chk
    import sysctr_pkg::*;
#(
    parameter int unsigned ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [REG_W-1:0]  bus_wdata,
    input logic [REG_W-1:0]  bus_rdata,
    input logic [CNT_W-1:0]  count_value,
    input logic              ctl_en,
    input logic              ctl_sen
);
    logic wr_ctrl, wr_lo, wr_hi, wr_cnt;
    assign wr_ctrl = bus_we && (bus_addr == ADDR_W'(OFF_CTRL));
    assign wr_lo   = bus_we && (bus_addr == ADDR_W'(OFF_CNTLO));
    assign wr_hi   = bus_we && (bus_addr == ADDR_W'(OFF_CNTHI));
    assign wr_cnt  = wr_lo || wr_hi;

    p_hold_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_en && !wr_cnt) |=> $stable(count_value));

    p_unit_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_en && !ctl_sen && tick && !wr_cnt) |=> (count_value == $past(count_value) + 1'b1));

    p_write_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !wr_hi) |=> (count_value[REG_W-1:0] == $past(bus_wdata)));

    p_write_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !wr_lo) |=> (count_value[CNT_W-1:REG_W] == $past(bus_wdata)));

    p_status_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFF_STAT)) |-> (bus_rdata == '0));

    p_ctrl_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !tick && !wr_cnt) |=> $stable(count_value));

    p_carry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_en && !ctl_sen && tick && !wr_cnt && (&count_value[REG_W-1:0]))
        |=> (count_value[CNT_W-1:REG_W] == $past(count_value[CNT_W-1:REG_W]) + 1'b1));
endmodule

bind sysctr_top sysctr_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .count_value (count_value),
    .ctl_en      (ctl_en),
    .ctl_sen     (ctl_sen)
);

// File: tb/test_sysctr_top.sv
module test_sysctr_top;
    localparam int unsigned ADDR_W = 5;
    localparam int unsigned NVEC   = 13;
    // vector: {op[1:0], addr[7:0], data[31:0], req[7:0]}; op 0=write 1=tick n 2=read-check
    localparam logic [49:0] VEC [NVEC] = '{
        {2'd0, 8'h00, 32'h0,        8'd2},
        {2'd1, 8'h00, 32'd100,      8'd2},
        {2'd2, 8'h08, 32'd0,        8'd2},
        {2'd0, 8'h00, 32'h1,        8'd3},
        {2'd1, 8'h00, 32'd100,      8'd3},
        {2'd2, 8'h08, 32'd100,      8'd3},
        {2'd2, 8'h0C, 32'd0,        8'd3},
        {2'd0, 8'h00, 32'h0,        8'd5},
        {2'd0, 8'h10, 32'h00100000, 8'd5},
        {2'd0, 8'h00, 32'h5,        8'd4},
        {2'd2, 8'h00, 32'h5,        8'd4},
        {2'd1, 8'h00, 32'd160,      8'd5},
        {2'd2, 8'h08, 32'd110,      8'd5}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [63:0]       count_value;
    int                n_run = 0;
    int                n_fail = 0;

    always #10 clk = ~clk;

    sysctr_top #(.ADDR_W(ADDR_W)) i_sysctr_top (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .count_value(count_value)
    );

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a[ADDR_W-1:0]; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
        end
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_addr = a[ADDR_W-1:0];
        #1;
        n_run++;
        if (bus_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%h actual=%h expected=%h", req, a, bus_rdata, exp);
        end
    endtask

    initial begin
        #3000000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_chk(8'h00, 32'h0, "R1");
        rd_chk(8'h08, 32'h0, "R1");
        rd_chk(8'h0C, 32'h0, "R1");
        rd_chk(8'h10, 32'h01000000, "R1");

        for (int v = 0; v < NVEC; v++) begin
            case (VEC[v][49:48])
                2'd0: wr(VEC[v][47:40], VEC[v][39:8]);
                2'd1: ticks(int'(VEC[v][39:8]));
                default: rd_chk(VEC[v][47:40], VEC[v][39:8], $sformatf("R%0d", VEC[v][7:0]));
            endcase
        end

        // R9: half a count pending, toggle scale-enable, fraction kept
        ticks(8);
        rd_chk(8'h08, 32'd110, "R5");
        wr(8'h00, 32'h1);
        rd_chk(8'h08, 32'd110, "R9");
        ticks(1);
        rd_chk(8'h08, 32'd111, "R9");
        wr(8'h00, 32'h5);
        ticks(8);
        rd_chk(8'h08, 32'd112, "R9");

        // R7: count write clears fraction
        ticks(8);
        wr(8'h08, 32'd200);
        ticks(8);
        rd_chk(8'h08, 32'd200, "R7");

        // R7: write in same cycle as enabled tick wins
        wr(8'h00, 32'h1);
        @(negedge clk);
        bus_addr = 5'h08; bus_wdata = 32'd300; bus_we = 1'b1; tick = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; tick = 1'b0;
        rd_chk(8'h08, 32'd300, "R7");

        // R6/R10: high half write and carry
        wr(8'h0C, 32'h0000ABCD);
        rd_chk(8'h0C, 32'h0000ABCD, "R6");
        wr(8'h0C, 32'h0);
        wr(8'h08, 32'hFFFFFFFF);
        ticks(1);
        rd_chk(8'h08, 32'h0, "R10");
        rd_chk(8'h0C, 32'h1, "R10");

        // R8: status ignores writes
        wr(8'h04, 32'hFFFFFFFF);
        rd_chk(8'h04, 32'h0, "R8");
        rd_chk(8'h08, 32'h0, "R8");

        // R2: disabled again, ticks ignored
        wr(8'h00, 32'h0);
        ticks(20);
        rd_chk(8'h08, 32'h0, "R2");
        rd_chk(8'h00, 32'h0, "R4");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule